// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block receives characters from an idle-high asynchronous serial line. A free-running divider produces a tick, and the line is oversampled at 16 ticks per bit. Each start bit is confirmed again at its midpoint, and every later bit is sampled at its centre. The number of data bits is a parameter, and so are the oversampling ratio and the tick divider. The mode inputs choose an optional parity bit with even or odd sense, and one or two stop bits.

Software sees two byte-wide registers through a simple read/write port. A status register holds a receive-data-full flag and two sticky error flags, one for framing and one for parity. A data register holds the last character received. A character that has an error is still stored, but the full flag is not raised for it. While either error flag is set, the receiver accepts no new character. Software clears an error flag in two steps: it reads the flag as 1, then writes 0 to it. A receive-enable input gates reception and leaves the error flags unchanged.

Top module: `async_rx`

## Requirements
- R1: A character is a start bit (0), then the data bits least significant first, then an optional parity bit, then the stop bit(s). Each bit is sampled at its centre using 16x oversampling. A start bit that is not still 0 at its midpoint is discarded.
- R2: With parity_en_i=1, parity_odd_i=0 selects even sense: the count of 1s in the data and parity bits together must be even. parity_odd_i=1 selects odd sense. A mismatch sets the parity error flag, which is status bit 2. With parity_en_i=0 no parity bit is expected.
- R3: With two_stop_i=1 only the first stop bit is checked. A 0 on the second stop bit raises no error, and the character is accepted normally.
- R4: A first stop bit sampled as 0 sets the framing error flag, which is status bit 1.
- R5: When a character has a framing or parity error, it is still written to the data register (address 1), but the full flag is not set.
- R6: While either error flag is 1, no new character is received: the data register and the full flag stay unchanged.
- R7: A status write (address 0) clears an error flag only where the written bit is 0 and a status read since the flag was set returned it as 1. A write of 0 without such a read leaves the flag set, and a write of 1 has no effect.
- R8: While rx_en_i=0 no character is received, and both error flags keep their values.
- R9: The full flag is status bit 0. It is set by an error-free character and cleared by a read of the data register. If that read falls in the same cycle a character is stored, the flag stays set. Writes to status bit 0 are ignored.
- R10: After reset, status and data both read as 0. Status bits 7..3 always read 0. The data register is zero-extended to the register width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_en_i | input | 1 | Receive enable |
| parity_en_i | input | 1 | Expect a parity bit after the data |
| parity_odd_i | input | 1 | Parity sense: 0 even, 1 odd |
| two_stop_i | input | 1 | Two stop bits (only the first is checked) |
| rxd_i | input | 1 | Serial line, idle high |
| reg_addr_i | input | 1 | Register select: 0 status, 1 data |
| reg_rd_i | input | 1 | Read strobe, one cycle per access |
| reg_wr_i | input | 1 | Write strobe, one cycle per access |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data for the selected register (combinational) |

## Verification
Two events can fall in the same clock cycle: a software read of the data register, which clears the full flag, and the storing of a new character, which sets it. The bench provokes this with a sweep. It sends a series of distinct characters and places a single data read at a different clock offset around the stop-bit sample for each one. Each outcome is judged by the value the read returned. If the read returned the new character, the full flag must afterwards be 0. If it returned the previous character, the read came before or together with the store, so the flag must still be 1.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_SKIP
  } rx_state_e;

  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
  localparam int   FULL_BIT  = 0;
  localparam int   ERR_BASE  = 1;  // err[0] framing, err[1] parity
  localparam int   ERR_N     = 2;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;  // line idles high
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 rx_i,
  input  logic                 run_i,     // receive enable
  input  logic                 accept_i,  // no error flag pending
  input  logic                 par_en_i,
  input  logic                 par_odd_i,
  input  logic                 two_stop_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] char_o,
  output logic                 fer_o,
  output logic                 per_o
);
  localparam int HALF = OSR / 2;
  localparam int PH_W = $clog2(OSR) + 1;
  localparam int BC_W = $clog2(DATA_BITS + 1);

  rx_state_e            st_q;
  logic [PH_W-1:0]      ph_q;
  logic [BC_W-1:0]      bc_q;
  logic [DATA_BITS-1:0] sh_q;
  logic                 par_q, done_q, fer_q, per_q;
  logic                 bit_end;

  assign bit_end = (ph_q == PH_W'(OSR - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      bc_q   <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      done_q <= 1'b0;
      fer_q  <= 1'b0;
      per_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!run_i) begin
        st_q <= ST_IDLE;
        ph_q <= '0;
      end else if (tick_i) begin
        unique case (st_q)
          ST_IDLE: if (accept_i && !rx_i) begin
            st_q <= ST_START;
            ph_q <= '0;
          end
          ST_START: begin
            if (ph_q == PH_W'(HALF - 1)) begin
              ph_q <= '0;
              bc_q <= '0;
              st_q <= rx_i ? ST_IDLE : ST_DATA;  // glitch rejected
            end else ph_q <= ph_q + 1'b1;
          end
          ST_DATA: begin
            if (bit_end) begin
              ph_q <= '0;
              sh_q <= {rx_i, sh_q[DATA_BITS-1:1]};
              bc_q <= bc_q + 1'b1;
              if (bc_q == BC_W'(DATA_BITS - 1))
                st_q <= par_en_i ? ST_PAR : ST_STOP;
            end else ph_q <= ph_q + 1'b1;
          end
          ST_PAR: begin
            if (bit_end) begin
              ph_q  <= '0;
              par_q <= rx_i;
              st_q  <= ST_STOP;
            end else ph_q <= ph_q + 1'b1;
          end
          ST_STOP: begin
            if (bit_end) begin
              ph_q   <= '0;
              done_q <= 1'b1;
              fer_q  <= !rx_i;
              per_q  <= par_en_i && ((^{sh_q, par_q}) != par_odd_i);
              st_q   <= two_stop_i ? ST_SKIP : ST_IDLE;
            end else ph_q <= ph_q + 1'b1;
          end
          ST_SKIP: begin
            // second stop bit is not checked: wait past its end
            if (ph_q == PH_W'(OSR + HALF - 1)) begin
              ph_q <= '0;
              st_q <= ST_IDLE;
            end else ph_q <= ph_q + 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign char_o = sh_q;
  assign fer_o  = fer_q;
  assign per_o  = per_q;
endmodule

// File: rtl/rx_regs.sv
module rx_regs
  import rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int REG_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 commit_i,
  input  logic [DATA_BITS-1:0] char_i,
  input  logic                 fer_i,
  input  logic                 per_i,
  input  logic                 addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic                 block_o,
  output logic                 full_o,
  output logic [ERR_N-1:0]     err_o,
  output logic [DATA_BITS-1:0] data_o
);
  logic [DATA_BITS-1:0] data_q;
  logic                 full_q;
  logic [ERR_N-1:0]     err_q, arm_q, err_set;
  logic                 stat_rd, stat_wr, data_rd;
  logic                 unused_wdata;

  assign stat_rd = rd_i && (addr_i == ADDR_STAT);
  assign stat_wr = wr_i && (addr_i == ADDR_STAT);
  assign data_rd = rd_i && (addr_i == ADDR_DATA);
  assign err_set = {per_i, fer_i} & {ERR_N{commit_i}};
  assign unused_wdata = ^{wdata_i[REG_W-1:ERR_BASE+ERR_N], wdata_i[FULL_BIT]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (commit_i) data_q <= char_i;
      if (commit_i && !fer_i && !per_i) full_q <= 1'b1;  // set wins
      else if (data_rd)                 full_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < ERR_N; i++) begin : g_err
    logic clr;
    assign clr = stat_wr && arm_q[i] && !wdata_i[ERR_BASE+i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        err_q[i] <= 1'b0;
        arm_q[i] <= 1'b0;
      end else begin
        if (err_set[i]) err_q[i] <= 1'b1;
        else if (clr)   err_q[i] <= 1'b0;
        if (clr)                        arm_q[i] <= 1'b0;
        else if (stat_rd && err_q[i])   arm_q[i] <= 1'b1;
      end
    end
  end

  assign rdata_o = (addr_i == ADDR_DATA) ? REG_W'(data_q)
                 : {{(REG_W-ERR_N-1){1'b0}}, err_q, full_q};
  assign block_o = |err_q;
  assign full_o  = full_q;
  assign err_o   = err_q;
  assign data_o  = data_q;
endmodule

// File: rtl/async_rx.sv
module async_rx
  import rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16,
  parameter int TICK_DIV  = 3,
  parameter int REG_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             parity_en_i,
  input  logic             parity_odd_i,
  input  logic             two_stop_i,
  input  logic             rxd_i,
  input  logic             reg_addr_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o
);
  logic                 tick_w, rx_w, busy_w, commit_w, c_fer_w, c_per_w;
  logic                 block_w, full_w;
  logic [ERR_N-1:0]     err_w;
  logic [DATA_BITS-1:0] char_w, data_w;

  rx_tick_gen #(.DIV(TICK_DIV)) i_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick_w)
  );

  rx_sync #(.STAGES(2)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rx_w)
  );

  rx_frame #(.DATA_BITS(DATA_BITS), .OSR(OSR)) i_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w), .rx_i(rx_w),
    .run_i(rx_en_i), .accept_i(!block_w), .par_en_i(parity_en_i),
    .par_odd_i(parity_odd_i), .two_stop_i(two_stop_i), .busy_o(busy_w),
    .done_o(commit_w), .char_o(char_w), .fer_o(c_fer_w), .per_o(c_per_w)
  );

  rx_regs #(.DATA_BITS(DATA_BITS), .REG_W(REG_W)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit_w), .char_i(char_w),
    .fer_i(c_fer_w), .per_i(c_per_w), .addr_i(reg_addr_i), .rd_i(reg_rd_i),
    .wr_i(reg_wr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .block_o(block_w), .full_o(full_w), .err_o(err_w), .data_o(data_w)
  );
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter int DATA_BITS = 8,
  parameter int REG_W     = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rx_en_i,
  input logic                 reg_addr_i,
  input logic                 reg_rd_i,
  input logic                 reg_wr_i,
  input logic [REG_W-1:0]     reg_wdata_i,
  input logic                 busy_i,
  input logic                 commit_i,
  input logic                 c_fer_i,
  input logic                 c_per_i,
  input logic [DATA_BITS-1:0] char_i,
  input logic                 full_i,
  input logic [1:0]           err_i,
  input logic [DATA_BITS-1:0] data_i
);
  // R5
  err_no_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && (c_fer_i || c_per_i) && !full_i |=> !full_i);
  // R5
  data_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> data_i == $past(char_i));
  // R6
  block_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_i) && !busy_i |=> !busy_i);
  // R7
  fer_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_i[0]) |-> $past(reg_wr_i && !reg_addr_i && !reg_wdata_i[1]));
  // R7
  per_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_i[1]) |-> $past(reg_wr_i && !reg_addr_i && !reg_wdata_i[2]));
  // R8
  err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|err_i) |-> $past(commit_i));
  // R8
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !busy_i);
  // R9
  full_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !c_fer_i && !c_per_i |=> full_i);
  // R9
  full_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i && reg_addr_i && !commit_i |=> !full_i);
endmodule

bind async_rx async_rx_chk #(.DATA_BITS(DATA_BITS), .REG_W(REG_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .reg_addr_i(reg_addr_i),
  .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
  .busy_i(busy_w), .commit_i(commit_w), .c_fer_i(c_fer_w), .c_per_i(c_per_w),
  .char_i(char_w), .full_i(full_w), .err_i(err_w), .data_i(data_w)
);

// File: tb/test_async_rx.sv
module test_async_rx;
  localparam int OSR      = 16;
  localparam int TICK_DIV = 3;
  localparam int BIT_CLKS = OSR * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic       rxd = 1'b1;
  logic       addr = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  async_rx #(.DATA_BITS(8), .OSR(OSR), .TICK_DIV(TICK_DIV), .REG_W(8)) i_async_rx (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .parity_en_i(par_en),
    .parity_odd_i(par_odd), .two_stop_i(two_stop), .rxd_i(rxd),
    .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata)
  );

  function automatic logic par_bit(input logic [7:0] c, input logic odd);
    return (^c) ^ odd;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_read(input logic a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic reg_write(input logic a, input logic [7:0] v);
    @(negedge clk);
    addr = a; wdata = v; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic line_bit(input logic b);
    rxd = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] c, input logic pe, input logic odd,
                      input logic ts, input logic bad_par, input logic s1,
                      input logic s2);
    @(negedge clk);
    par_en = pe; par_odd = odd; two_stop = ts;
    line_bit(1'b0);
    for (int i = 0; i < 8; i++) line_bit(c[i]);
    if (pe) line_bit(par_bit(c, odd) ^ bad_par);
    line_bit(s1);
    if (ts) line_bit(s2);
    line_bit(1'b1);
    line_bit(1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, c, old, got;
    logic       pe, odd, ts;
    v = $urandom(32'h5EED_0451);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    reg_read(1'b0, v); chk("R10 reset status", v, 8'h00);
    reg_read(1'b1, v); chk("R10 reset data", v, 8'h00);
    rx_en = 1'b1;

    // random error-free characters across all modes
    for (int i = 0; i < 24; i++) begin
      c = 8'($urandom); pe = 1'($urandom); odd = 1'($urandom); ts = 1'($urandom);
      send(c, pe, odd, ts, 1'b0, 1'b1, 1'b1);
      reg_read(1'b0, v); chk("R1 R2 status after good char", v, 8'h01);
      reg_read(1'b1, v); chk("R1 data", v, c);
      reg_read(1'b0, v); chk("R9 full cleared by data read", v, 8'h00);
    end

    // parity error, even sense
    send(8'hA5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    reg_read(1'b1, v); chk("R5 data kept on parity error", v, 8'hA5);
    send(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    reg_read(1'b1, v); chk("R6 blocked while flag set", v, 8'hA5);
    reg_write(1'b0, 8'h00);
    reg_read(1'b0, v); chk("R7 write 0 without read keeps flag, R2 R5", v, 8'h04);
    reg_write(1'b0, 8'hFF);
    reg_read(1'b0, v); chk("R7 write 1 no effect", v, 8'h04);
    reg_write(1'b0, 8'h00);
    reg_read(1'b0, v); chk("R7 read then write 0 clears", v, 8'h00);
    send(8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    reg_read(1'b0, v); chk("R6 reception resumes", v, 8'h01);
    reg_read(1'b1, v); chk("R6 resumed data", v, 8'h5A);

    // framing error, flags kept while disabled
    send(8'h81, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    rx_en = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    reg_read(1'b0, v); chk("R4 R8 framing flag kept with enable low", v, 8'h02);
    reg_read(1'b1, v); chk("R5 data kept on framing error", v, 8'h81);
    reg_write(1'b0, 8'h00);
    reg_read(1'b0, v); chk("R7 framing flag cleared", v, 8'h00);
    send(8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    reg_read(1'b0, v); chk("R8 no reception when disabled", v, 8'h00);
    reg_read(1'b1, v); chk("R8 data unchanged when disabled", v, 8'h81);
    rx_en = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);

    // second stop bit low is ignored
    send(8'hC3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    reg_read(1'b0, v); chk("R3 second stop ignored", v, 8'h01);
    reg_read(1'b1, v); chk("R3 data", v, 8'hC3);

    // full bit not writable
    send(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    reg_write(1'b0, 8'h00);
    reg_read(1'b0, v); chk("R9 write 0 to full ignored", v, 8'h01);
    reg_write(1'b0, 8'hFF);
    reg_read(1'b0, v); chk("R9 write 1 to full ignored", v, 8'h01);

    // data read swept across the store cycle
    old = 8'h11;
    par_en = 1'b0; two_stop = 1'b0;
    for (int k = 0; k < 14; k++) begin
      c = 8'h40 + 8'(k);
      line_bit(1'b0);
      for (int i = 0; i < 8; i++) line_bit(c[i]);
      rxd = 1'b1;
      repeat (BIT_CLKS / 2 - 4 + k) @(negedge clk);
      reg_read(1'b1, got);
      repeat (3 * BIT_CLKS) @(negedge clk);
      reg_read(1'b0, v);
      if (got === c)        chk("R9 read after store clears full", v, 8'h00);
      else if (got === old) chk("R9 read before or with store keeps full", v, 8'h01);
      else                  chk("R9 sweep read value", got, c);
      old = c;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule